// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Timing Tracker

This block follows the internal condition of every bank in a single-data-rate SDRAM. A controller or a memory model feeds it the command it has just registered: an operation code, an auto-precharge bit, a bank number and a start column. The block answers with one state flag per bank (idle, open, bursting, write recovery, precharging). It also reports which write beat the data bus carries in the current cycle and produces a read-data-valid strobe delayed by the CAS latency.

Bursts are four beats long. A write burst's first beat travels with the WRITE command, and the beat column climbs by one each cycle. An accepted READ or WRITE to a different bank cuts a running burst short in the cycle that command is registered. The cut bank then loses every later beat. If that burst was a write with auto precharge, its write-recovery interval counts from the interrupting cycle rather than from the end of a full burst. After write recovery the bank precharges for tRP cycles and returns to idle. A command aimed at a bank that is recovering or precharging changes nothing and raises a one-cycle error flag.

Top module: `sdr_bank_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bank reads idle, and `wr_accept`, `rd_valid` and `proto_err` are 0.
- R2: An ACTIVE (`cmd_op`=1) to an idle bank opens it from the next cycle. A READ (`cmd_op`=2) or WRITE (`cmd_op`=3) to an open bank marks it bursting from the next cycle. The bit of index i in each flag vector belongs to bank i.
- R3: A write burst has four beat slots: the command cycle and the three cycles after it. Their columns are start, start+1, start+2 and start+3, modulo 2^COL_W. In a slot `wr_accept` equals `wdata_vld`, and `beat_bank`/`beat_col` name the target.
- R4: A write with auto precharge (`cmd_ap`=1) that is not interrupted spends T_WR cycles in write recovery, starting the cycle after its last slot. It then spends T_RP cycles precharging and then goes idle.
- R5: An accepted READ or WRITE to another bank ends a running burst in the cycle it is registered. From that cycle on, the cut bank receives no beat, and any write beats belong to the new bank.
- R6: A write with auto precharge that is cut off counts its cutting cycle as the first write-recovery cycle. It shows T_WR-1 recovery cycles, then T_RP precharge cycles, then idle.
- R7: Each read beat slot (the READ command cycle plus three more, unless cut off) gives `rd_valid`=1 exactly CAS_LAT cycles later, with `rd_col` equal to that slot's column.
- R8: An interrupting command that carries auto precharge runs its own full burst and then its own recovery: write recovery for T_WR cycles followed by precharge for a write, or precharge for T_RP cycles for a read. The interrupted bank's timing does not affect it.
- R9: A burst without auto precharge, whether it ends naturally or is cut off, returns its bank to open.
- R10: An ACTIVE, READ or WRITE to a bank in write recovery or precharge sets `proto_err` for exactly the next cycle. It alters no bank's state and does not cut off another bank's burst.
- R11: A read with auto precharge that is not interrupted precharges for T_RP cycles, starting the cycle after its last slot, and then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Registered command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE |
| cmd_ap | input | 1 | Auto-precharge bit for READ/WRITE |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Start column of READ/WRITE |
| wdata_vld | input | 1 | Write data present on the bus this cycle |
| bank_idle | output | NBANK | Bank idle |
| bank_open | output | NBANK | Row open, no burst |
| bank_xfer | output | NBANK | Burst in progress |
| bank_wrec | output | NBANK | Write recovery |
| bank_pchg | output | NBANK | Precharging |
| wr_accept | output | 1 | A write beat is taken this cycle |
| beat_bank | output | BANK_W | Bank of the accepted beat |
| beat_col | output | COL_W | Column of the accepted beat |
| rd_valid | output | 1 | Read data valid, CAS_LAT after its slot |
| rd_col | output | COL_W | Column of the valid read beat |
| proto_err | output | 1 | Command hit a recovering or precharging bank |

## Verification
The key coincidence is an interrupting command that arrives in the same cycle as the interrupted burst's last natural slot. Natural termination and interruption then compete for the same bank, and interruption must win, shortening write recovery by one cycle. The sweep hits this case by placing the interrupt at every slot offset from one through three, for every ordered bank pair, both interrupting operations and both auto-precharge settings. Each cycle is judged against timelines computed from T_WR, T_RP and CAS_LAT. A second coincidence is also provoked: an illegal command to a recovering bank issued during another bank's write burst. That burst's beats must continue while the error flag pulses.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        BK_IDLE = 3'd0,
        BK_OPEN = 3'd1,
        BK_XFER = 3'd2,
        BK_WREC = 3'd3,
        BK_PCHG = 3'd4
    } bk_e;

endpackage

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_trk_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int T_WR  = 2,
    parameter int T_RP  = 3,
    parameter int BL    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_act,
    input  logic             go_xfer,
    input  logic             xfer_wr,
    input  logic             xfer_ap,
    input  logic [COL_W-1:0] xfer_col,
    input  logic             other_xfer,
    output bk_e              st_o,
    output logic             slot_o,
    output logic             slot_wr_o,
    output logic [COL_W-1:0] col_o
);

    localparam int BEAT_W  = (BL > 1) ? $clog2(BL) : 1;
    localparam int TMAX    = (T_WR > T_RP) ? T_WR : T_RP;
    localparam int TMR_W   = $clog2(TMAX + 1);
    localparam int WR_CUT  = (T_WR > 1) ? T_WR - 2 : 0;

    typedef struct packed {
        bk_e               st;
        logic              wr;
        logic              ap;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  col;
        logic [TMR_W-1:0]  tmr;
    } bank_s;

    bank_s bank_q, bank_d;
    logic  cut_c, last_c;

    always_comb begin
        bank_d = bank_q;
        cut_c  = 1'b0;
        last_c = 1'b0;
        case (bank_q.st)
            BK_IDLE: begin
                if (go_act) bank_d.st = BK_OPEN;
            end
            BK_OPEN, BK_XFER: begin
                cut_c  = (bank_q.st == BK_XFER) && other_xfer;
                last_c = (bank_q.st == BK_XFER) && (bank_q.beat == BEAT_W'(BL - 1));
                if (go_xfer) begin
                    bank_d.st   = BK_XFER;
                    bank_d.wr   = xfer_wr;
                    bank_d.ap   = xfer_ap;
                    bank_d.beat = BEAT_W'(1);
                    bank_d.col  = xfer_col;
                end else if (cut_c || last_c) begin
                    bank_d.beat = '0;
                    if (bank_q.wr && bank_q.ap) begin
                        if (cut_c && (T_WR == 1)) begin
                            bank_d.st  = BK_PCHG;
                            bank_d.tmr = TMR_W'(T_RP - 1);
                        end else begin
                            bank_d.st  = BK_WREC;
                            bank_d.tmr = cut_c ? TMR_W'(WR_CUT) : TMR_W'(T_WR - 1);
                        end
                    end else if (bank_q.ap) begin
                        bank_d.st  = BK_PCHG;
                        bank_d.tmr = TMR_W'(T_RP - 1);
                    end else begin
                        bank_d.st = BK_OPEN;
                    end
                end else if (bank_q.st == BK_XFER) begin
                    bank_d.beat = bank_q.beat + BEAT_W'(1);
                end
            end
            BK_WREC: begin
                if (bank_q.tmr == '0) begin
                    bank_d.st  = BK_PCHG;
                    bank_d.tmr = TMR_W'(T_RP - 1);
                end else begin
                    bank_d.tmr = bank_q.tmr - TMR_W'(1);
                end
            end
            BK_PCHG: begin
                if (bank_q.tmr == '0) bank_d.st = BK_IDLE;
                else                  bank_d.tmr = bank_q.tmr - TMR_W'(1);
            end
            default: bank_d.st = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign st_o      = bank_q.st;
    assign slot_o    = (bank_q.st == BK_XFER) && !other_xfer && !go_xfer;
    assign slot_wr_o = bank_q.wr;
    assign col_o     = bank_q.col + COL_W'(bank_q.beat);

    AST_WREC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_WREC) |=> (bank_q.st == BK_WREC || bank_q.st == BK_PCHG))
        else $error("write recovery left to a wrong state"); // R4

    AST_PCHG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_PCHG) |=> (bank_q.st == BK_PCHG || bank_q.st == BK_IDLE))
        else $error("precharge left to a wrong state"); // R11

    AST_CUT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_XFER && bank_q.wr && bank_q.ap && other_xfer)
        |=> (bank_q.st == BK_WREC || bank_q.st == BK_PCHG))
        else $error("cut write burst did not enter recovery"); // R6

    AST_BUSY_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_WREC || bank_q.st == BK_PCHG) |=> (bank_q.st != BK_OPEN && bank_q.st != BK_XFER))
        else $error("busy bank reopened"); // R10

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int COL_W   = 8,
    parameter int CAS_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [COL_W-1:0] push_col,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col
);

    typedef struct packed {
        logic [CAS_LAT-1:0]            vld;
        logic [CAS_LAT-1:0][COL_W-1:0] col;
    } pipe_s;

    pipe_s pipe_q, pipe_d;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld[0] = push;
        pipe_d.col[0] = push_col;
        for (int k = 1; k < CAS_LAT; k++) begin
            pipe_d.vld[k] = pipe_q.vld[k-1];
            pipe_d.col[k] = pipe_q.col[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rd_valid = pipe_q.vld[CAS_LAT-1];
    assign rd_col   = pipe_q.col[CAS_LAT-1];

    AST_RD_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.vld == '0 && !push) |=> !rd_valid)
        else $error("read valid with empty pipe"); // R7

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
    import sdr_trk_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int COL_W   = 8,
    parameter int T_WR    = 2,
    parameter int T_RP    = 3,
    parameter int CAS_LAT = 3,
    parameter int BL      = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_ap,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              wdata_vld,
    output logic [NBANK-1:0]  bank_idle,
    output logic [NBANK-1:0]  bank_open,
    output logic [NBANK-1:0]  bank_xfer,
    output logic [NBANK-1:0]  bank_wrec,
    output logic [NBANK-1:0]  bank_pchg,
    output logic              wr_accept,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              rd_valid,
    output logic [COL_W-1:0]  rd_col,
    output logic              proto_err
);

    typedef struct packed {
        logic err;
    } top_s;

    top_s top_q, top_d;

    bk_e              st_w     [NBANK];
    logic [COL_W-1:0] col_w    [NBANK];
    logic [NBANK-1:0] slot_w;
    logic [NBANK-1:0] slot_wr_w;
    logic [NBANK-1:0] go_act_w;
    logic [NBANK-1:0] go_xfer_w;
    logic [NBANK-1:0] other_w;

    bk_e              tgt_st;
    logic             busy_c, act_ok_c, xfer_ok_c, err_c;
    logic             any_slot_c, slot_is_wr_c;
    logic [BANK_W-1:0] slot_bank_c;
    logic [COL_W-1:0]  slot_col_c;

    assign tgt_st    = st_w[cmd_bank];
    assign busy_c    = (tgt_st == BK_WREC) || (tgt_st == BK_PCHG);
    assign act_ok_c  = (cmd_op == OP_ACT) && (tgt_st == BK_IDLE);
    assign xfer_ok_c = ((cmd_op == OP_RD) || (cmd_op == OP_WR)) &&
                       ((tgt_st == BK_OPEN) || (tgt_st == BK_XFER));
    assign err_c     = (cmd_op != OP_NOP) && busy_c;

    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_bank
            assign go_act_w[gi]  = act_ok_c  && (cmd_bank == BANK_W'(gi));
            assign go_xfer_w[gi] = xfer_ok_c && (cmd_bank == BANK_W'(gi));
            assign other_w[gi]   = xfer_ok_c && (cmd_bank != BANK_W'(gi));

            sdr_bank_fsm #(
                .COL_W (COL_W),
                .T_WR  (T_WR),
                .T_RP  (T_RP),
                .BL    (BL)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .go_act     (go_act_w[gi]),
                .go_xfer    (go_xfer_w[gi]),
                .xfer_wr    (cmd_op == OP_WR),
                .xfer_ap    (cmd_ap),
                .xfer_col   (cmd_col),
                .other_xfer (other_w[gi]),
                .st_o       (st_w[gi]),
                .slot_o     (slot_w[gi]),
                .slot_wr_o  (slot_wr_w[gi]),
                .col_o      (col_w[gi])
            );

            assign bank_idle[gi] = (st_w[gi] == BK_IDLE);
            assign bank_open[gi] = (st_w[gi] == BK_OPEN);
            assign bank_xfer[gi] = (st_w[gi] == BK_XFER);
            assign bank_wrec[gi] = (st_w[gi] == BK_WREC);
            assign bank_pchg[gi] = (st_w[gi] == BK_PCHG);
        end
    endgenerate

    always_comb begin
        any_slot_c   = 1'b0;
        slot_is_wr_c = 1'b0;
        slot_bank_c  = '0;
        slot_col_c   = '0;
        if (xfer_ok_c) begin
            any_slot_c   = 1'b1;
            slot_is_wr_c = (cmd_op == OP_WR);
            slot_bank_c  = cmd_bank;
            slot_col_c   = cmd_col;
        end else begin
            for (int i = 0; i < NBANK; i++) begin
                if (slot_w[i]) begin
                    any_slot_c   = 1'b1;
                    slot_is_wr_c = slot_wr_w[i];
                    slot_bank_c  = BANK_W'(i);
                    slot_col_c   = col_w[i];
                end
            end
        end
    end

    always_comb begin
        top_d     = top_q;
        top_d.err = err_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign wr_accept = any_slot_c && slot_is_wr_c && wdata_vld;
    assign beat_bank = wr_accept ? slot_bank_c : '0;
    assign beat_col  = wr_accept ? slot_col_c  : '0;
    assign proto_err = top_q.err;

    sdr_rd_pipe #(
        .COL_W   (COL_W),
        .CAS_LAT (CAS_LAT)
    ) u_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (any_slot_c && !slot_is_wr_c),
        .push_col (slot_col_c),
        .rd_valid (rd_valid),
        .rd_col   (rd_col)
    );

    AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_xfer))
        else $error("two banks bursting at once"); // R5

    AST_BEAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (bank_xfer != '0 || cmd_op == OP_WR))
        else $error("write beat with no burst"); // R3

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && cmd_op == OP_NOP) |=> !proto_err)
        else $error("error flag held"); // R10

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bank_idle[0], bank_open[0], bank_xfer[0], bank_wrec[0], bank_pchg[0]}) == 1)
        else $error("bank 0 flags not one-hot"); // R2

endmodule

// File: tb/sdr_bank_tracker_bench.sv
module sdr_bank_tracker_bench;

    localparam int NBANK = 4;
    localparam int COL_W = 8;
    localparam int TWR   = 2;
    localparam int TRP   = 3;
    localparam int CL    = 3;
    localparam int BL    = 4;
    localparam int LEN   = 24;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       cmd_op;
    logic             cmd_ap;
    logic [1:0]       cmd_bank;
    logic [COL_W-1:0] cmd_col;
    logic             wdata_vld;
    logic [NBANK-1:0] bank_idle, bank_open, bank_xfer, bank_wrec, bank_pchg;
    logic             wr_accept;
    logic [1:0]       beat_bank;
    logic [COL_W-1:0] beat_col;
    logic             rd_valid;
    logic [COL_W-1:0] rd_col;
    logic             proto_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdr_bank_tracker #(
        .NBANK(NBANK), .COL_W(COL_W), .T_WR(TWR), .T_RP(TRP), .CAS_LAT(CL), .BL(BL)
    ) u_sdr_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ap(cmd_ap), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .wdata_vld(wdata_vld), .bank_idle(bank_idle), .bank_open(bank_open),
        .bank_xfer(bank_xfer), .bank_wrec(bank_wrec), .bank_pchg(bank_pchg),
        .wr_accept(wr_accept), .beat_bank(beat_bank), .beat_col(beat_col),
        .rd_valid(rd_valid), .rd_col(rd_col), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // 0 idle, 1 open, 2 burst, 3 recovery, 4 precharge, 7 not one-hot
    function automatic int code_of(input int b);
        logic [4:0] f;
        f = {bank_pchg[b], bank_wrec[b], bank_xfer[b], bank_open[b], bank_idle[b]};
        case (f)
            5'b00001: return 0;
            5'b00010: return 1;
            5'b00100: return 2;
            5'b01000: return 3;
            5'b10000: return 4;
            default:  return 7;
        endcase
    endfunction

    // kind: 0 back to open, 1 recovery (wlen) then precharge, 2 precharge, 3 always idle
    function automatic int exp_st(input int r, input int rb, input int re, input int kind, input int wlen);
        int rr;
        if (kind == 3) return 0;
        if (r <= rb) return 1;
        if (r <= re) return 2;
        rr = r - re - 1;
        if (kind == 0) return 1;
        if (kind == 1) begin
            if (rr < wlen) return 3;
            if (rr < wlen + TRP) return 4;
            return 0;
        end
        if (rr < TRP) return 4;
        return 0;
    endfunction

    task automatic drive(input int op, input bit ap, input int bank, input int col, input bit wv);
        @(posedge clk);
        #2;
        cmd_op    = 2'(op);
        cmd_ap    = ap;
        cmd_bank  = 2'(bank);
        cmd_col   = COL_W'(col);
        wdata_vld = wv;
        #13;
    endtask

    task automatic check_beats(input string req, input bit eacc, input int eb, input int ec);
        chk(wr_accept == eacc, req, int'(wr_accept), int'(eacc));
        if (eacc) begin
            chk(int'(beat_bank) == eb, req, int'(beat_bank), eb);
            chk(int'(beat_col) == (ec & 8'hFF), req, int'(beat_col), ec & 8'hFF);
        end
    endtask

    task automatic check_rd(input bit erd, input int ec);
        chk(rd_valid == erd, "R7", int'(rd_valid), int'(erd));
        if (erd) chk(int'(rd_col) == (ec & 8'hFF), "R7", int'(rd_col), ec & 8'hFF);
    endtask

    task automatic close_bank(input int b);
        drive(2, 1'b1, b, 0, 1'b0);
        repeat (BL + CL + TRP + 2) drive(0, 1'b0, 0, 0, 1'b0);
    endtask

    // write with auto precharge on n, cut at slot k by op to m
    task automatic run_cut(input int n, input int m, input int k, input bit iwr, input bit iap);
        int a, d, kind_m, e;
        a = 40 + n;
        d = 200 + m;
        kind_m = iap ? (iwr ? 1 : 2) : 0;
        drive(1, 1'b0, n, 0, 1'b0);
        drive(1, 1'b0, m, 0, 1'b0);
        for (int r = 0; r < LEN; r++) begin
            if (r == 0)      drive(3, 1'b1, n, a, 1'b1);
            else if (r == k) drive(iwr ? 3 : 2, iap, m, d, 1'b1);
            else             drive(0, 1'b0, 0, 0, 1'b1);
            for (int b = 0; b < NBANK; b++) begin
                if (b == n)      e = exp_st(r, 0, k, 1, TWR - 1);
                else if (b == m) e = exp_st(r, k, k + BL - 1, kind_m, TWR);
                else             e = 0;
                if (b == n)      chk(code_of(b) == e, (r <= 1) ? "R2" : "R6", code_of(b), e);
                else if (b == m) chk(code_of(b) == e, iap ? "R8" : "R9", code_of(b), e);
                else             chk(code_of(b) == e, "R5", code_of(b), e);
            end
            if (r < k)                          check_beats("R5", 1'b1, n, a + r);
            else if (iwr && r < k + BL)         check_beats("R5", 1'b1, m, d + r - k);
            else                                check_beats("R5", 1'b0, 0, 0);
            if (!iwr && r >= k + CL && r < k + CL + BL) check_rd(1'b1, d + r - k - CL);
            else                                        check_rd(1'b0, 0);
            chk(proto_err == 1'b0, "R10", int'(proto_err), 0);
        end
        if (!iap) close_bank(m);
    endtask

    // single burst with a data-valid mask pattern
    task automatic run_solo(input int b, input bit iwr, input bit iap, input int col, input logic [3:0] msk);
        int kind, e;
        kind = iap ? (iwr ? 1 : 2) : 0;
        drive(1, 1'b0, b, 0, 1'b0);
        for (int r = 0; r < LEN; r++) begin
            if (r == 0) drive(iwr ? 3 : 2, iap, b, col, msk[0]);
            else        drive(0, 1'b0, 0, 0, (r < BL) ? msk[r] : 1'b0);
            for (int j = 0; j < NBANK; j++) begin
                e = (j == b) ? exp_st(r, 0, BL - 1, kind, TWR) : 0;
                chk(code_of(j) == e, (!iap) ? "R9" : (iwr ? "R4" : "R11"), code_of(j), e);
            end
            if (iwr && r < BL) check_beats("R3", msk[r], b, col + r);
            else               check_beats("R3", 1'b0, 0, 0);
            if (!iwr && r >= CL && r < CL + BL) check_rd(1'b1, col + r - CL);
            else                                check_rd(1'b0, 0);
        end
        if (!iap) close_bank(b);
    endtask

    // commands to a busy bank while another bank writes
    task automatic run_err();
        int e1, e2, e3, e;
        e1 = BL + TWR - 1;
        e2 = BL + TWR;
        e3 = BL + TWR + TRP - 1;
        drive(1, 1'b0, 0, 0, 1'b0);
        drive(1, 1'b0, 1, 0, 1'b0);
        for (int r = 0; r < LEN; r++) begin
            if (r == 0)       drive(3, 1'b1, 0, 8'h30, 1'b1);
            else if (r == BL) drive(3, 1'b1, 1, 8'h50, 1'b1);
            else if (r == e1) drive(2, 1'b0, 0, 8'h77, 1'b1);
            else if (r == e2) drive(1, 1'b0, 0, 0, 1'b1);
            else if (r == e3) drive(3, 1'b0, 0, 8'h66, 1'b1);
            else              drive(0, 1'b0, 0, 0, 1'b1);
            e = exp_st(r, 0, BL - 1, 1, TWR);
            chk(code_of(0) == e, "R10", code_of(0), e);
            e = exp_st(r, BL, 2 * BL - 1, 1, TWR);
            chk(code_of(1) == e, "R10", code_of(1), e);
            if (r < BL)            check_beats("R10", 1'b1, 0, 8'h30 + r);
            else if (r < 2 * BL)   check_beats("R10", 1'b1, 1, 8'h50 + r - BL);
            else                   check_beats("R10", 1'b0, 0, 0);
            e = (r == e1 + 1 || r == e2 + 1 || r == e3 + 1) ? 1 : 0;
            chk(int'(proto_err) == e, "R10", int'(proto_err), e);
            check_rd(1'b0, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; cmd_op = 2'd0; cmd_ap = 1'b0; cmd_bank = '0; cmd_col = '0; wdata_vld = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk(bank_idle == 4'hF, "R1", int'(bank_idle), 15);
        chk(rd_valid == 1'b0 && proto_err == 1'b0, "R1", int'({rd_valid, proto_err}), 0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        drive(0, 1'b0, 0, 0, 1'b1);
        chk(bank_idle == 4'hF, "R1", int'(bank_idle), 15);
        chk(wr_accept == 1'b0 && rd_valid == 1'b0 && proto_err == 1'b0, "R1",
            int'({wr_accept, rd_valid, proto_err}), 0);

        for (int b = 0; b < NBANK; b++) begin
            run_solo(b, 1'b1, 1'b1, 8'hFE, 4'b1111);
            run_solo(b, 1'b1, 1'b0, 8'h10 + b, 4'b0101);
            run_solo(b, 1'b0, 1'b1, 8'h20 + b, 4'b0000);
            run_solo(b, 1'b0, 1'b0, 8'hFD, 4'b0000);
        end
        for (int n = 0; n < NBANK; n++)
            for (int m = 0; m < NBANK; m++)
                if (m != n)
                    for (int k = 1; k < BL; k++)
                        for (int op = 0; op < 2; op++)
                            for (int ap = 0; ap < 2; ap++)
                                run_cut(n, m, k, op[0], ap[0]);
        run_err();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule